// File: doc/BRIEF.md
# Multi-Precision Reconfigurable Multiplier Array

This block multiplies signed integers at three precisions on one shared pool of nine small signed multiplier units. Each unit Booth-encodes its multiplier in radix 4 and sums the partial products through a carry-save reduction. A two-bit precision code, sampled on every cycle the block is free, decides how the pool is split. The pool can run nine independent 8x8 products, up to three 16x16 products, or one 32x32 product. Operands arrive on packed buses with one valid bit per lane, and products leave on a packed bus with one valid bit per lane. A unit that the current operation does not use keeps its operand registers unchanged, so its logic does not switch.

A 16x16 lane takes three units. They form the high-by-high product, the low-by-low product and the product of the two half differences, and the cross term is recovered from these three. Operand bytes are therefore widened to 10 bits inside each unit. A 32x32 product needs sixteen byte-by-byte sub-products. Nine are issued in a first pass and seven in a second. The block is busy for two cycles while the first pass is summed into an accumulator, and it delivers the result in the third cycle, in which it also accepts a new operation.

The control sequencer has four states: `ST_IDLE` (accepting), `ST_ISSUE2` (second pass issued, busy), `ST_GATHER` (first pass summed into the accumulator, busy) and `ST_DELIVER` (32-bit result on the outputs, accepting). Its transitions are:

- `ST_IDLE`/`ST_DELIVER` → `ST_ISSUE2` on an accepted 32x32 request.
- `ST_IDLE`/`ST_DELIVER` → `ST_IDLE` otherwise.
- `ST_ISSUE2` → `ST_GATHER` unconditionally.
- `ST_GATHER` → `ST_DELIVER` unconditionally.

Top module: `mpm_array`

## Requirements
- R1: Every unit returns the exact two's-complement product of its two signed operands. This holds for the extreme byte values -128 (0x80), 127 (0x7F), 0 and -1 (0xFF).
- R2: Precision code 00 gives nine independent signed 8x8 lanes. Lane i takes its operands from a_bus[8i+7:8i] and b_bus[8i+7:8i]. Its 16-bit product appears on p_bus[16i+15:16i] with out_valid[i] exactly two cycles after in_valid[i] was sampled.
- R3: Precision code 01 gives up to three signed 16x16 lanes, k = 0..2, with valid bit in_valid[k]. Lane k takes its operands from a_bus[16k+15:16k] and b_bus[16k+15:16k]. Its 32-bit product appears on p_bus[32k+31:32k] with out_valid[k] two cycles later, and in_valid[8:3] is ignored.
- R4: Precision code 10 with in_valid[0] starts one signed 32x32 product of a_bus[31:0] and b_bus[31:0]. The 64-bit result appears on p_bus[63:0] with out_valid = 9'b000000001 three cycles after the request was sampled.
- R5: busy is high for exactly the two cycles after an accepted 32x32 request. Every input sampled while busy is high is ignored and produces no output.
- R6: Precision code 11 is reserved. It produces no out_valid bit and no product.
- R7: A lane whose valid bit is low produces out_valid low. Every p_bus field without a valid bit reads zero.
- R8: During and after reset, out_valid, busy and p_bus are all zero.
- R9: The precision code may change on any accepting cycle. Each result is formed with the code that was sampled together with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Precision code: 00 bytes, 01 halves, 10 word, 11 reserved |
| in_valid | input | 9 | Per-lane operand valid |
| a_bus | input | 72 | Packed multiplicand lanes |
| b_bus | input | 72 | Packed multiplier lanes |
| busy | output | 1 | High while a 32x32 operation occupies the array |
| out_valid | output | 9 | Per-lane product valid |
| p_bus | output | 144 | Packed product lanes |

## Verification
A wrong Booth digit or carry in a unit shows up as a wrong product field two cycles after the lane was issued. In the word precision, a fault in the pass routing or the accumulator corrupts only p_bus[63:0], and it does so in the third cycle after the request. A sequencer that leaves its busy states early or late changes the busy pulse width. It also moves the word-result cycle, or it lets an input sampled during busy produce a stray valid bit two cycles later. A mode tag that does not follow its operands through the pipeline puts products in the wrong field layout in the cycle they come out.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

    // Precision code carried on the mode input
    typedef enum logic [1:0] {
        MD_BYTE = 2'b00,
        MD_HALF = 2'b01,
        MD_WORD = 2'b10,
        MD_RSV  = 2'b11
    } mode_e;

    // Sequencer for the two-pass word multiplication
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE2,
        ST_GATHER,
        ST_DELIVER
    } wstate_e;

    // Operand routing choice for the unit pool
    typedef enum logic [2:0] {
        RT_NONE,
        RT_BYTE,
        RT_HALF,
        RT_WORD0,
        RT_WORD1
    } route_e;

    // Register stages from operand sampling to product for byte and half lanes
    localparam int NARROW_LAT = 2;
    // Byte sub-products of a word product
    localparam int WORD_SUBS  = 16;

endpackage

// File: rtl/mpm_booth_unit.sv
module mpm_booth_unit #(
    parameter  int OPW = 10,
    localparam int PW  = 2 * OPW,
    localparam int ND  = OPW / 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    output logic [PW-1:0]  prod_q
);

    logic [OPW-1:0] a_q, b_q;
    logic [OPW:0]   bx;
    logic [PW-1:0]  pp [ND];
    logic [PW-1:0]  a_x, a_2x, s_v, c_v, t_v, prod_d;

    // Operand registers only move when the unit is assigned work
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (en) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    // Radix-4 digit selection
    always_comb begin
        a_x  = {{OPW{a_q[OPW-1]}}, a_q};
        a_2x = a_x << 1;
        bx   = {b_q, 1'b0};
        for (int d = 0; d < ND; d++) begin
            case (bx[2*d +: 3])
                3'b001, 3'b010: pp[d] = a_x << (2 * d);
                3'b011:         pp[d] = a_2x << (2 * d);
                3'b100:         pp[d] = (-a_2x) << (2 * d);
                3'b101, 3'b110: pp[d] = (-a_x) << (2 * d);
                default:        pp[d] = '0;
            endcase
        end
    end

    // Carry-save reduction followed by one carry-propagate add
    always_comb begin
        s_v = '0;
        c_v = '0;
        t_v = '0;
        for (int d = 0; d < ND; d++) begin
            t_v = s_v ^ c_v ^ pp[d];
            c_v = ((s_v & c_v) | (s_v & pp[d]) | (c_v & pp[d])) << 1;
            s_v = t_v;
        end
        prod_d = s_v + c_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_d;
    end

    // R1
    booth_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $signed(prod_q) == $signed($past(a_q)) * $signed($past(b_q)));

endmodule

// File: rtl/mpm_route.sv
module mpm_route
    import mpm_pkg::*;
#(
    parameter  int UW  = 8,
    parameter  int NU  = 9,
    localparam int OPW = UW + 2,
    localparam int AW  = NU * UW,
    localparam int WW  = 4 * UW
) (
    input  route_e            sel,
    input  logic [AW-1:0]     a_bus,
    input  logic [AW-1:0]     b_bus,
    input  logic [WW-1:0]     hold_a,
    input  logic [WW-1:0]     hold_b,
    output logic [NU*OPW-1:0] ua,
    output logic [NU*OPW-1:0] ub
);

    function automatic logic [OPW-1:0] xt(input logic [UW-1:0] v, input logic sgn);
        return {{(OPW-UW){sgn & v[UW-1]}}, v};
    endfunction

    for (genvar u = 0; u < NU; u++) begin : g_unit
        localparam int K  = u / 3;              // half lane served
        localparam int R  = u % 3;              // role within that lane
        localparam int I0 = u / 4;              // first-pass byte of a
        localparam int J0 = u % 4;              // first-pass byte of b
        localparam int P1 = u + NU;             // second-pass sub-product index
        localparam int I1 = (P1 / 4) % 4;
        localparam int J1 = P1 % 4;
        localparam bit HAS_P1 = (P1 < WORD_SUBS);

        logic [OPW-1:0] ah, al, bh, bl, oa, ob;

        always_comb begin
            ah = xt(a_bus[2*UW*K + UW +: UW], 1'b1);
            al = xt(a_bus[2*UW*K +: UW], 1'b0);
            bh = xt(b_bus[2*UW*K + UW +: UW], 1'b1);
            bl = xt(b_bus[2*UW*K +: UW], 1'b0);
            oa = '0;
            ob = '0;
            unique case (sel)
                RT_BYTE: begin
                    oa = xt(a_bus[UW*u +: UW], 1'b1);
                    ob = xt(b_bus[UW*u +: UW], 1'b1);
                end
                RT_HALF: begin
                    if (R == 0) begin
                        oa = ah;
                        ob = bh;
                    end else if (R == 1) begin
                        oa = al;
                        ob = bl;
                    end else begin
                        oa = ah - al;
                        ob = bh - bl;
                    end
                end
                RT_WORD0: begin
                    oa = xt(a_bus[UW*I0 +: UW], I0 == 3);
                    ob = xt(b_bus[UW*J0 +: UW], J0 == 3);
                end
                RT_WORD1: begin
                    if (HAS_P1) begin
                        oa = xt(hold_a[UW*I1 +: UW], I1 == 3);
                        ob = xt(hold_b[UW*J1 +: UW], J1 == 3);
                    end
                end
                default: ;
            endcase
        end

        assign ua[OPW*u +: OPW] = oa;
        assign ub[OPW*u +: OPW] = ob;
    end

endmodule

// File: rtl/mpm_ctrl.sv
module mpm_ctrl
    import mpm_pkg::*;
#(
    parameter  int UW   = 8,
    parameter  int NU   = 9,
    localparam int AW   = NU * UW,
    localparam int WW   = 4 * UW,
    localparam int NL16 = NU / 3,
    localparam int NW1  = WORD_SUBS - NU
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic [NU-1:0] in_valid,
    input  logic [AW-1:0] a_bus,
    input  logic [AW-1:0] b_bus,
    output logic [NU-1:0] unit_en,
    output route_e        sel,
    output logic [WW-1:0] hold_a,
    output logic [WW-1:0] hold_b,
    output logic          busy,
    output logic          acc_load,
    output logic          word_valid,
    output mode_e         s2_mode,
    output logic [NU-1:0] s2_vld
);

    localparam logic [NU-1:0] HALF_LANES = NU'((1 << NL16) - 1);
    localparam logic [NU-1:0] PASS1_UNITS = NU'((1 << NW1) - 1);

    wstate_e       st, nxt;
    mode_e         tag_mode, s1_mode;
    logic [NU-1:0] tag_vld, s1_vld;
    logic          take_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt        = st;
        unit_en    = '0;
        sel        = RT_NONE;
        busy       = 1'b0;
        acc_load   = 1'b0;
        word_valid = 1'b0;
        tag_mode   = MD_RSV;
        tag_vld    = '0;
        take_word  = 1'b0;
        unique case (st)
            ST_ISSUE2: begin
                busy    = 1'b1;
                unit_en = PASS1_UNITS;
                sel     = RT_WORD1;
                nxt     = ST_GATHER;
            end
            ST_GATHER: begin
                busy     = 1'b1;
                acc_load = 1'b1;
                nxt      = ST_DELIVER;
            end
            ST_IDLE, ST_DELIVER: begin
                word_valid = (st == ST_DELIVER);
                nxt        = ST_IDLE;
                unique case (mode)
                    MD_BYTE: begin
                        unit_en  = in_valid;
                        sel      = RT_BYTE;
                        tag_mode = MD_BYTE;
                        tag_vld  = in_valid;
                    end
                    MD_HALF: begin
                        for (int k = 0; k < NL16; k++)
                            unit_en[3*k +: 3] = {3{in_valid[k]}};
                        sel      = RT_HALF;
                        tag_mode = MD_HALF;
                        tag_vld  = in_valid & HALF_LANES;
                    end
                    MD_WORD: begin
                        if (in_valid[0]) begin
                            unit_en   = '1;
                            sel       = RT_WORD0;
                            take_word = 1'b1;
                            nxt       = ST_ISSUE2;
                        end
                    end
                    default: ;
                endcase
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Word operands kept for the second pass; lane tags follow the unit pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_a  <= '0;
            hold_b  <= '0;
            s1_mode <= MD_RSV;
            s1_vld  <= '0;
            s2_mode <= MD_RSV;
            s2_vld  <= '0;
        end else begin
            if (take_word) begin
                hold_a <= a_bus[WW-1:0];
                hold_b <= b_bus[WW-1:0];
            end
            s1_mode <= tag_mode;
            s1_vld  <= tag_vld;
            s2_mode <= s1_mode;
            s2_vld  <= s1_vld;
        end
    end

    // R5
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    // R4
    word_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode == MD_WORD && in_valid[0]) |=> busy);

    // R6
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode == MD_RSV) |=> ##1 (s2_vld == '0));

endmodule

// File: rtl/mpm_combine.sv
module mpm_combine
    import mpm_pkg::*;
#(
    parameter  int UW   = 8,
    parameter  int NU   = 9,
    localparam int OPW  = UW + 2,
    localparam int PW   = 2 * OPW,
    localparam int WW   = 4 * UW,
    localparam int PRW  = 2 * WW,
    localparam int PBW  = NU * 2 * UW,
    localparam int NL16 = NU / 3,
    localparam int NW1  = WORD_SUBS - NU
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NU*PW-1:0] prods,
    input  mode_e          s2_mode,
    input  logic [NU-1:0]  s2_vld,
    input  logic           acc_load,
    input  logic           word_valid,
    output logic [NU-1:0]  out_valid,
    output logic [PBW-1:0] p_bus
);

    function automatic logic [PRW-1:0] widen(input logic [PW-1:0] p, input int sh);
        logic [PRW-1:0] w;
        w = {{(PRW-PW){p[PW-1]}}, p};
        return w << sh;
    endfunction

    logic [PRW-1:0] sum0, sum1, acc, word_sum;
    logic [PRW-1:0] hres [NL16];

    // First-pass and second-pass sub-product sums, weighted by byte position
    always_comb begin
        sum0 = '0;
        for (int u = 0; u < NU; u++)
            sum0 = sum0 + widen(prods[PW*u +: PW], UW * ((u / 4) + (u % 4)));
        sum1 = '0;
        for (int u = 0; u < NW1; u++)
            sum1 = sum1 + widen(prods[PW*u +: PW], UW * (((u + NU) / 4) + ((u + NU) % 4)));
        word_sum = acc + sum1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc <= '0;
        else if (acc_load) acc <= sum0;
    end

    // Half lanes: high, low and difference products give the cross term
    always_comb begin
        for (int k = 0; k < NL16; k++) begin
            hres[k] = widen(prods[PW*(3*k) +: PW], 2 * UW)
                    + ((widen(prods[PW*(3*k) +: PW], 0)
                      + widen(prods[PW*(3*k+1) +: PW], 0)
                      - widen(prods[PW*(3*k+2) +: PW], 0)) << UW)
                    + widen(prods[PW*(3*k+1) +: PW], 0);
        end
    end

    always_comb begin
        out_valid = '0;
        p_bus     = '0;
        if (word_valid) begin
            out_valid[0]    = 1'b1;
            p_bus[PRW-1:0]  = word_sum;
        end else if (s2_mode == MD_BYTE) begin
            for (int u = 0; u < NU; u++) begin
                if (s2_vld[u]) begin
                    out_valid[u]           = 1'b1;
                    p_bus[2*UW*u +: 2*UW]  = prods[PW*u +: 2*UW];
                end
            end
        end else if (s2_mode == MD_HALF) begin
            for (int k = 0; k < NL16; k++) begin
                if (s2_vld[k]) begin
                    out_valid[k]       = 1'b1;
                    p_bus[WW*k +: WW]  = hres[k][WW-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/mpm_array.sv
module mpm_array
    import mpm_pkg::*;
#(
    parameter  int UNIT_W = 8,
    localparam int NU     = 9,
    localparam int OPW    = UNIT_W + 2,
    localparam int PW     = 2 * OPW,
    localparam int AW     = NU * UNIT_W,
    localparam int WW     = 4 * UNIT_W,
    localparam int PBW    = NU * 2 * UNIT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode,
    input  logic [NU-1:0]  in_valid,
    input  logic [AW-1:0]  a_bus,
    input  logic [AW-1:0]  b_bus,
    output logic           busy,
    output logic [NU-1:0]  out_valid,
    output logic [PBW-1:0] p_bus
);

    logic [NU-1:0]     unit_en;
    route_e            sel;
    logic [WW-1:0]     hold_a, hold_b;
    logic              acc_load, word_valid;
    mode_e             s2_mode;
    logic [NU-1:0]     s2_vld;
    logic [NU*OPW-1:0] ua, ub;
    logic [NU*PW-1:0]  prods;

    mpm_ctrl #(.UW(UNIT_W), .NU(NU)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_e'(mode)),
        .in_valid   (in_valid),
        .a_bus      (a_bus),
        .b_bus      (b_bus),
        .unit_en    (unit_en),
        .sel        (sel),
        .hold_a     (hold_a),
        .hold_b     (hold_b),
        .busy       (busy),
        .acc_load   (acc_load),
        .word_valid (word_valid),
        .s2_mode    (s2_mode),
        .s2_vld     (s2_vld)
    );

    mpm_route #(.UW(UNIT_W), .NU(NU)) u_route (
        .sel    (sel),
        .a_bus  (a_bus),
        .b_bus  (b_bus),
        .hold_a (hold_a),
        .hold_b (hold_b),
        .ua     (ua),
        .ub     (ub)
    );

    for (genvar u = 0; u < NU; u++) begin : g_pool
        mpm_booth_unit #(.OPW(OPW)) u_unit (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (unit_en[u]),
            .a_in   (ua[OPW*u +: OPW]),
            .b_in   (ub[OPW*u +: OPW]),
            .prod_q (prods[PW*u +: PW])
        );
    end

    mpm_combine #(.UW(UNIT_W), .NU(NU)) u_combine (
        .clk        (clk),
        .rst_n      (rst_n),
        .prods      (prods),
        .s2_mode    (s2_mode),
        .s2_vld     (s2_vld),
        .acc_load   (acc_load),
        .word_valid (word_valid),
        .out_valid  (out_valid),
        .p_bus      (p_bus)
    );

    // R4
    word_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid == NU'(1));

    // R7
    lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode == 2'b00 && !in_valid[NU-1]) |=> ##1 !out_valid[NU-1]);

endmodule

// File: tb/mpm_array_test.sv
module mpm_array_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   mode;
    logic [8:0]   in_valid;
    logic [71:0]  a_bus, b_bus;
    logic         busy;
    logic [8:0]   out_valid;
    logic [143:0] p_bus;

    mpm_array uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .in_valid  (in_valid),
        .a_bus     (a_bus),
        .b_bus     (b_bus),
        .busy      (busy),
        .out_valid (out_valid),
        .p_bus     (p_bus)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R8";

    // Expected outputs, one slot per future cycle
    logic [143:0] exp_p [8];
    logic [8:0]   exp_v [8];
    logic         exp_b [8];
    int           cyc   = 0;
    int           mbusy = 0;

    // Behavioural reference: decide at each sampling edge what must appear later
    always @(posedge clk) begin
        if (rst_n) begin
            int cur;
            cur = cyc;
            cyc = cyc + 1;
            if (mbusy > 0) begin
                mbusy = mbusy - 1;
            end else if (mode == 2'b00) begin
                for (int i = 0; i < 9; i++) begin
                    if (in_valid[i]) begin
                        longint pa, pb, pr;
                        pa = longint'($signed(a_bus[8*i +: 8]));
                        pb = longint'($signed(b_bus[8*i +: 8]));
                        pr = pa * pb;
                        exp_v[(cur+2)%8][i] = 1'b1;
                        exp_p[(cur+2)%8][16*i +: 16] = pr[15:0];
                    end
                end
            end else if (mode == 2'b01) begin
                for (int k = 0; k < 3; k++) begin
                    if (in_valid[k]) begin
                        longint pa, pb, pr;
                        pa = longint'($signed(a_bus[16*k +: 16]));
                        pb = longint'($signed(b_bus[16*k +: 16]));
                        pr = pa * pb;
                        exp_v[(cur+2)%8][k] = 1'b1;
                        exp_p[(cur+2)%8][32*k +: 32] = pr[31:0];
                    end
                end
            end else if (mode == 2'b10 && in_valid[0]) begin
                longint pa, pb;
                pa = longint'($signed(a_bus[31:0]));
                pb = longint'($signed(b_bus[31:0]));
                exp_v[(cur+3)%8][0] = 1'b1;
                exp_p[(cur+3)%8][63:0] = pa * pb;
                exp_b[(cur+1)%8] = 1'b1;
                exp_b[(cur+2)%8] = 1'b1;
                mbusy = 2;
            end
        end
    end

    task automatic compare_now();
        int s;
        s = cyc % 8;
        n_cmp++;
        if (out_valid !== exp_v[s] || p_bus !== exp_p[s] || busy !== exp_b[s]) begin
            n_bad++;
            $display("FAIL %s cycle %0d: out_valid=%h exp %h busy=%b exp %b p_bus=%h exp %h",
                     tag, cyc, out_valid, exp_v[s], busy, exp_b[s], p_bus, exp_p[s]);
        end
        exp_v[s] = '0;
        exp_p[s] = '0;
        exp_b[s] = 1'b0;
    endtask

    task automatic step(input logic [1:0] md, input logic [8:0] vin,
                        input logic [71:0] a, input logic [71:0] b);
        @(negedge clk);
        compare_now();
        mode     = md;
        in_valid = vin;
        a_bus    = a;
        b_bus    = b;
    endtask

    function automatic logic [71:0] rnd72();
        return 72'({$urandom(), $urandom(), $urandom()});
    endfunction

    initial begin
        logic [7:0]  c8  [5];
        logic [15:0] c16 [5];
        logic [31:0] c32 [5];
        c8  = '{8'h80, 8'h7F, 8'h00, 8'hFF, 8'h01};
        c16 = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001};
        c32 = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h1};
        for (int s = 0; s < 8; s++) begin
            exp_v[s] = '0;
            exp_p[s] = '0;
            exp_b[s] = 1'b0;
        end
        rst_n    = 1'b0;
        mode     = 2'b00;
        in_valid = '0;
        a_bus    = '0;
        b_bus    = '0;

        // R8: reset state, inputs active while reset is held
        repeat (3) begin
            @(negedge clk);
            n_cmp++;
            if (out_valid !== '0 || busy !== 1'b0 || p_bus !== '0) begin
                n_bad++;
                $display("FAIL R8 reset: out_valid=%h busy=%b p_bus=%h exp 0 0 0",
                         out_valid, busy, p_bus);
            end
            in_valid = '1;
            a_bus    = rnd72();
            b_bus    = rnd72();
        end
        in_valid = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: extreme byte pairs through every unit
        tag = "R1";
        for (int t = 0; t < 10; t++) begin
            logic [71:0] a, b;
            for (int i = 0; i < 9; i++) begin
                a[8*i +: 8] = c8[(i + t) % 5];
                b[8*i +: 8] = c8[(2*i + t / 2) % 5];
            end
            step(2'b00, 9'h1FF, a, b);
        end

        // R2: all byte lanes, random operands
        tag = "R2";
        for (int t = 0; t < 40; t++) step(2'b00, 9'h1FF, rnd72(), rnd72());

        // R7: byte lanes with random valid patterns
        tag = "R7";
        for (int t = 0; t < 40; t++) step(2'b00, 9'($urandom()), rnd72(), rnd72());

        // R3: half lanes, corner pairs then random, upper valid bits set as noise
        tag = "R3";
        for (int t = 0; t < 25; t++) begin
            logic [71:0] a, b;
            a = rnd72();
            b = rnd72();
            for (int k = 0; k < 3; k++) begin
                a[16*k +: 16] = c16[(t + k) % 5];
                b[16*k +: 16] = c16[(t / 5 + 2*k) % 5];
            end
            step(2'b01, 9'h1FF, a, b);
        end
        for (int t = 0; t < 40; t++) step(2'b01, 9'($urandom()), rnd72(), rnd72());

        // R4: word products, corner pairs, next request in the delivery cycle
        tag = "R4";
        for (int t = 0; t < 25; t++) begin
            logic [71:0] a, b;
            a = rnd72();
            b = rnd72();
            a[31:0] = c32[t % 5];
            b[31:0] = c32[t / 5];
            step(2'b10, 9'h001, a, b);
            step(2'b00, 9'h000, '0, '0);
            step(2'b00, 9'h000, '0, '0);
        end
        for (int t = 0; t < 15; t++) begin
            step(2'b10, 9'h001, rnd72(), rnd72());
            step(2'b00, 9'h000, '0, '0);
            step(2'b00, 9'h000, '0, '0);
        end

        // R5: junk requests of every kind while busy must vanish
        tag = "R5";
        for (int t = 0; t < 20; t++) begin
            step(2'b10, 9'h001, rnd72(), rnd72());
            step(2'($urandom()), 9'h1FF, rnd72(), rnd72());
            step(2'($urandom()), 9'h1FF, rnd72(), rnd72());
        end

        // R6: reserved code never yields a product
        tag = "R6";
        for (int t = 0; t < 12; t++) step(2'b11, 9'($urandom()), rnd72(), rnd72());

        // R9: precision changes from cycle to cycle
        tag = "R9";
        for (int t = 0; t < 250; t++)
            step(2'($urandom()), 9'($urandom()), rnd72(), rnd72());

        tag = "R7";
        for (int t = 0; t < 6; t++) step(2'b00, 9'h000, '0, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected end before %0d cycles", WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule